// File: doc/BRIEF.md
# Gate Driver Fault Sequencer

This block is the digital supervision logic that sits between a controller's drive command and the output stage of an isolated power-switch gate driver. It passes the command to the gate output and withholds it when the bias supply is too low, the die is too hot, enable is low, or a desaturation fault is latched. It reports faults on an active-low open-drain line. That line is modelled here as `flt_pd_o`, the enable of its pull-down transistor, so `flt_pd_o = 1` means the line is pulled low.

Supply and thermal faults are handled in two timed steps. First the fault line is pulled low. A second, longer delay later, the gate output is forced off. The gap gives the controller time for an orderly shutdown. If the condition clears during either delay, the sequence is abandoned and the output never drops.

Each analog condition arrives as a pair of comparator bits, one for each hysteresis threshold. The block holds the hysteresis state itself. A desaturation flag comes from a companion latch. This block returns a one-cycle clear request to that latch on a clean rising edge of the command. Both delays are counted in clock cycles.

Top module: `gdfs_top`

## Requirements
- R1: After reset, `drive_o` stays 0 and `flt_pd_o` stays 0 whatever `cmd_i` does, until `vcc_above_on_i` has been sampled 1.
- R2: While both supply comparator bits are 0 (supply between the two thresholds), the supply state is kept. Before the first `vcc_above_on_i` the output stays off; after it, the output keeps following the command.
- R3: Call the edge that first samples `vcc_below_off_i = 1` edge 0. `flt_pd_o` becomes 1 after edge T_FLT_CYC+1 and not earlier. `drive_o` keeps following `cmd_i` through edge T_FLT_CYC+T_OFF_CYC+1 and is 0 after edge T_FLT_CYC+T_OFF_CYC+2.
- R4: Once the output has been forced off by undervoltage, it stays 0 and the fault line stays asserted until `vcc_above_on_i` is sampled 1. At that point the fault line is released and the output follows the command again.
- R5: `temp_over_i` starts the same two-step sequence with the same cycle counts as R3. Recovery needs `temp_under_i` sampled 1. `temp_over_i` returning to 0 alone is not enough.
- R6: While `en_i` is 0, `drive_o` is 0 from the next edge on, and `flt_pd_o` stays 0.
- R7: In normal operation, `drive_o` equals `cmd_i` as sampled at the previous edge, and `flt_pd_o` is 0.
- R8: If the supply or thermal condition clears before the output is forced off, the fault line is released and `drive_o` never leaves the command.
- R9: When `desat_i` is sampled 1, then at the next edge `drive_o` is 0 and `flt_pd_o` is 1. Both stay that way while the flag is set.
- R10: `desat_clr_o` pulses for exactly one cycle after an edge at which `cmd_i` is sampled 1 (having been 0 at the prior edge) and `desat_i` is 1, and only when no supply or thermal sequence is active. In every other case it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Logic-level drive command |
| en_i | input | 1 | Output enable, active high |
| vcc_above_on_i | input | 1 | Supply above the upper (turn-on) threshold |
| vcc_below_off_i | input | 1 | Supply below the lower (turn-off) threshold |
| temp_over_i | input | 1 | Die temperature above the shutdown threshold |
| temp_under_i | input | 1 | Die temperature below the recovery threshold |
| desat_i | input | 1 | Latched desaturation fault flag from the companion latch |
| drive_o | output | 1 | Gated drive to the output stage |
| flt_pd_o | output | 1 | Fault line pull-down enable (1 = line low) |
| desat_clr_o | output | 1 | One-cycle clear request to the desaturation latch |

## Verification
Two events can fall in the same cycle: a rising edge of the command that would clear a latched desaturation fault, and an active supply or thermal sequence. The bench latches a desaturation fault and starts an undervoltage sequence. While the sequence is still in its silent first delay, it raises the command. It then judges that no clear request appears and that the fault line stays low. After the supply recovers, a fresh command edge must produce the clear request, and the fault line must be released once the flag drops.

// File: rtl/gdfs_pkg.sv
package gdfs_pkg;
  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_RUN   = 3'd1,
    ST_WARN  = 3'd2,
    ST_ALERT = 3'd3,
    ST_OFF   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/gdfs_hyst.sv
module gdfs_hyst #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set dominates: an inconsistent comparator pair resolves to the safe side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= RST_VAL;
    else if (set_i)  q_q <= 1'b1;
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gdfs_seq.sv
module gdfs_seq
  import gdfs_pkg::*;
#(
  parameter int T_FLT = 1460,
  parameter int T_OFF = 2400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_low_i,
  input  logic       ot_hot_i,
  output seq_state_e state_o,
  output logic       live_o,
  output logic       run_o,
  output logic       flt_o
);
  localparam int T_MAX = (T_FLT > T_OFF) ? T_FLT : T_OFF;
  localparam int CW    = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] LIM_FLT = CW'(T_FLT - 1);
  localparam logic [CW-1:0] LIM_OFF = CW'(T_OFF - 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cond;

  assign cond = uv_low_i | ot_hot_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_BOOT: if (!uv_low_i) st_d = ST_RUN;
      ST_RUN: begin
        if (cond) begin
          st_d  = ST_WARN;
          cnt_d = '0;
        end
      end
      ST_WARN: begin
        if (!cond) st_d = ST_RUN;
        else if (cnt_q == LIM_FLT) begin
          st_d  = ST_ALERT;
          cnt_d = '0;
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_ALERT: begin
        if (!cond) st_d = ST_RUN;
        else if (cnt_q == LIM_OFF) st_d = ST_OFF;
        else cnt_d = cnt_q + CW'(1);
      end
      ST_OFF: if (!cond) st_d = ST_RUN;
      default: st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_BOOT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign live_o  = (st_q == ST_RUN) | (st_q == ST_WARN) | (st_q == ST_ALERT);
  assign run_o   = (st_q == ST_RUN);
  assign flt_o   = (st_q == ST_ALERT) | (st_q == ST_OFF);
endmodule

// File: rtl/gdfs_gate.sv
module gdfs_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic en_i,
  input  logic desat_i,
  input  logic live_i,
  input  logic run_i,
  output logic drive_o,
  output logic desat_flt_o,
  output logic clr_o
);
  logic cmd_d, drive_q, desat_q, clr_q;
  logic cmd_rise;

  assign cmd_rise = cmd_i & ~cmd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_d   <= 1'b0;
      drive_q <= 1'b0;
      desat_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      cmd_d   <= cmd_i;
      drive_q <= cmd_i & en_i & live_i & ~desat_i;
      desat_q <= desat_i;
      clr_q   <= cmd_rise & desat_i & run_i;
    end
  end

  assign drive_o     = drive_q;
  assign desat_flt_o = desat_q;
  assign clr_o       = clr_q;
endmodule

// File: rtl/gdfs_top.sv
module gdfs_top
  import gdfs_pkg::*;
#(
  parameter int T_FLT_CYC = 1460,
  parameter int T_OFF_CYC = 2400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic en_i,
  input  logic vcc_above_on_i,
  input  logic vcc_below_off_i,
  input  logic temp_over_i,
  input  logic temp_under_i,
  input  logic desat_i,
  output logic drive_o,
  output logic flt_pd_o,
  output logic desat_clr_o
);
  seq_state_e st;
  logic uv_low, ot_hot, live, run, seq_flt, desat_flt;

  gdfs_hyst #(.RST_VAL(1'b1)) i_uv_hyst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (vcc_below_off_i),
    .clr_i (vcc_above_on_i),
    .q_o   (uv_low)
  );

  gdfs_hyst #(.RST_VAL(1'b0)) i_ot_hyst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (temp_over_i),
    .clr_i (temp_under_i),
    .q_o   (ot_hot)
  );

  gdfs_seq #(.T_FLT(T_FLT_CYC), .T_OFF(T_OFF_CYC)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .uv_low_i(uv_low),
    .ot_hot_i(ot_hot),
    .state_o (st),
    .live_o  (live),
    .run_o   (run),
    .flt_o   (seq_flt)
  );

  gdfs_gate i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .en_i       (en_i),
    .desat_i    (desat_i),
    .live_i     (live),
    .run_i      (run),
    .drive_o    (drive_o),
    .desat_flt_o(desat_flt),
    .clr_o      (desat_clr_o)
  );

  assign flt_pd_o = seq_flt | desat_flt;
endmodule

// File: rtl/gdfs_chk.sv
module gdfs_chk
  import gdfs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       desat_i,
  input logic       drive_o,
  input logic       flt_pd_o,
  input logic       desat_clr_o,
  input seq_state_e st_i
);
  p_boot_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_BOOT |-> !drive_o);

  p_off_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_OFF |-> ($past(st_i) == ST_ALERT || $past(st_i) == ST_OFF));

  p_off_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_OFF |=> !drive_o);

  p_en_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drive_o);

  p_desat_kill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desat_i |=> (!drive_o && flt_pd_o));

  p_clr_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desat_clr_o |-> $past(st_i) == ST_RUN);

  p_clr_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desat_clr_o |=> !desat_clr_o);
endmodule

bind gdfs_top gdfs_chk i_gdfs_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .desat_i    (desat_i),
  .drive_o    (drive_o),
  .flt_pd_o   (flt_pd_o),
  .desat_clr_o(desat_clr_o),
  .st_i       (st)
);

// File: tb/test_gdfs_top.sv
`timescale 1ns/1ps
module test_gdfs_top;
  localparam int TF = 6;
  localparam int TO = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd = 1'b0, en = 1'b1, v_on = 1'b0, v_off = 1'b0;
  logic t_over = 1'b0, t_under = 1'b0, desat = 1'b0;
  logic drive, flt, clr;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  gdfs_top #(.T_FLT_CYC(TF), .T_OFF_CYC(TO)) i_gdfs_top (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .en_i(en),
    .vcc_above_on_i(v_on), .vcc_below_off_i(v_off),
    .temp_over_i(t_over), .temp_under_i(t_under), .desat_i(desat),
    .drive_o(drive), .flt_pd_o(flt), .desat_clr_o(clr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic supply_up();
    v_off = 1'b0; v_on = 1'b1; tick(1); v_on = 1'b0; tick(2);
  endtask

  // R1 / R2: power-up
  task automatic t_boot();
    cmd = 1'b1;
    tick(4);
    chk("R1 drive at boot", drive, 1'b0);
    chk("R1 fault at boot", flt, 1'b0);
    chk("R1 clear at boot", clr, 1'b0);
    tick(5);
    chk("R2 between thresholds before arm", drive, 1'b0);
    v_on = 1'b1; tick(1); v_on = 1'b0;
    tick(2);
    chk("R2 follows after arm, between thresholds", drive, 1'b1);
    chk("R7 fault released", flt, 1'b0);
  endtask

  // R7 / R10: follow command, no clear without flag
  task automatic t_follow();
    logic pat [5] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 5; i++) begin
      cmd = pat[i];
      tick(1);
      chk("R7 drive follows cmd", drive, pat[i]);
      chk("R10 no clear without flag", clr, 1'b0);
    end
  endtask

  // shared exact-cycle check for R3 / R5, stimulus already applied
  task automatic slow_seq(input string req);
    for (int k = 0; k <= TF + TO + 3; k++) begin
      tick(1);
      chk({req, " fault line timing"}, flt, (k >= TF + 1) ? 1'b1 : 1'b0);
      chk({req, " forced-off timing"}, drive, (k >= TF + TO + 2) ? 1'b0 : 1'b1);
    end
  endtask

  task automatic t_uv();
    cmd = 1'b1;
    v_off = 1'b1;
    slow_seq("R3");
    v_off = 1'b0;
    tick(6);
    chk("R4 held off between thresholds", drive, 1'b0);
    chk("R4 fault held", flt, 1'b1);
    v_on = 1'b1; tick(1); v_on = 1'b0;
    tick(1);
    chk("R4 fault released at upper threshold", flt, 1'b0);
    tick(1);
    chk("R4 drive resumes", drive, 1'b1);
  endtask

  task automatic t_ot();
    cmd = 1'b1;
    t_over = 1'b1;
    slow_seq("R5");
    t_over = 1'b0;
    tick(6);
    chk("R5 held off above recovery", drive, 1'b0);
    chk("R5 fault held above recovery", flt, 1'b1);
    t_under = 1'b1; tick(1); t_under = 1'b0;
    tick(2);
    chk("R5 fault released", flt, 1'b0);
    chk("R5 drive resumes", drive, 1'b1);
  endtask

  task automatic t_cancel();
    logic dropped = 1'b0;
    cmd = 1'b1;
    v_off = 1'b1;
    tick(TF + 3);
    chk("R8 fault asserted in window", flt, 1'b1);
    v_off = 1'b0; v_on = 1'b1;
    tick(1);
    v_on = 1'b0;
    for (int i = 0; i < TO + 4; i++) begin
      if (drive !== 1'b1) dropped = 1'b1;
      tick(1);
    end
    chk("R8 fault released after cancel", flt, 1'b0);
    chk("R8 output never dropped", dropped, 1'b0);
  endtask

  task automatic t_enable();
    cmd = 1'b1; en = 1'b0;
    tick(1);
    chk("R6 drive off with enable low", drive, 1'b0);
    tick(3);
    chk("R6 no fault on enable low", flt, 1'b0);
    en = 1'b1;
    tick(1);
    chk("R6 drive back with enable", drive, 1'b1);
  endtask

  task automatic t_desat();
    cmd = 1'b1; desat = 1'b1;
    tick(1);
    chk("R9 drive off on desat", drive, 1'b0);
    chk("R9 fault on desat", flt, 1'b1);
    cmd = 1'b0; tick(2);
    cmd = 1'b1; tick(1);
    chk("R10 clear pulse on cmd rise", clr, 1'b1);
    chk("R9 drive still off", drive, 1'b0);
    desat = 1'b0;
    tick(1);
    chk("R10 clear is one cycle", clr, 1'b0);
    chk("R9 drive resumes after clear", drive, 1'b1);
    chk("R9 fault released after clear", flt, 1'b0);
  endtask

  // R10: clear withheld while a slow sequence is active
  task automatic t_clash();
    logic seen = 1'b0;
    cmd = 1'b1; desat = 1'b1;
    tick(1);
    cmd = 1'b0;
    v_off = 1'b1;
    tick(3);
    cmd = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      if (clr !== 1'b0) seen = 1'b1;
    end
    chk("R10 no clear during slow fault", seen, 1'b0);
    chk("R10 fault line low", flt, 1'b1);
    v_off = 1'b0; v_on = 1'b1; tick(1); v_on = 1'b0;
    tick(2);
    cmd = 1'b0; tick(1);
    cmd = 1'b1; tick(1);
    chk("R10 clear after recovery", clr, 1'b1);
    desat = 1'b0;
    tick(2);
    chk("R10 fault released after recovery", flt, 1'b0);
    chk("R10 drive after recovery", drive, 1'b1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_boot();
    t_follow();
    t_uv();
    t_ot();
    t_cancel();
    t_enable();
    t_desat();
    t_clash();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end
endmodule